// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is one channel of a timer that produces a digital waveform on a single output. A free-running prescaler divides the system clock by 2, 8, 32 or 128. The divisor is chosen by a clock-select input. Each prescaled tick advances an up-counter that restarts from zero after it reaches RC-1. Two compare values, RA and RC, and a software trigger each carry their own output action: none, set, clear or toggle. Together these produce square waves, pulse trains and PWM signals whose period and duty cycle are set by RC and RA.

Software uses a narrow write port. The command word enables the channel clock, disables it, or issues a software trigger. Enabling the clock only arms the channel. Counting begins with the first software trigger, and that trigger may come in the same write as the enable. The trigger clears the counter and applies its own output action in the cycle of the write.

Top module: `cmp_wave_timer`

## Requirements
- R1: After reset, waveOut is 0, the channel clock is off, the counter is stopped at 0 and every action field is "none".
- R2: A command write with only the enable bit (wrAddr 0, bit 0) arms the channel but does not start it. waveOut does not change until a software trigger arrives.
- R3: A software trigger (wrAddr 0, bit 2) issued together with enable, or while the clock is already enabled, restarts the counter at 0. It applies the trigger action to waveOut at the clock edge of the write.
- R4: Each prescaled tick steps the counter up. When the counter is at RC-1 or above, it wraps to 0 and the RC event fires. The RA event fires when the new count equals RA. With RA action set and RC action clear, the period is RC ticks and the output is high for RC-RA ticks.
- R5: With the RC action set to toggle, waveOut has a period of 2*RC ticks.
- R6: Action codes are 0 none, 1 set, 2 clear, 3 toggle. In the mode word (wrAddr 1), the RA action sits in bits [1:0], the RC action in bits [3:2] and the trigger action in bits [5:4]. RA is written at wrAddr 2 and RC at wrAddr 3.
- R7: clkSel values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clk cycles, taken from a prescaler that runs freely from reset.
- R8: When events coincide, the software trigger wins over RC, and RC wins over RA. With RA=0, the RC action alone acts at the wrap.
- R9: While RC is 0, the counter stays at 0 and no RA or RC event fires.
- R10: The disable command (bit 1) stops counting and freezes waveOut, and it wins over enable in the same write. A trigger while the clock is off is ignored.
- R11: RA and RC can be rewritten while the channel runs. The new values are used from the next tick, and waveOut changes only through the programmed actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 command, 1 mode, 2 RA, 3 RC |
| wrData | input | CNT_W | Write data |
| clkSel | input | SEL_W | Prescaler select (0 to 3) |
| waveOut | output | 1 | Waveform output |

## Verification
A command, mode or compare write at a clock edge changes the channel's state at that same edge. The result of a trigger is therefore visible on waveOut one half-cycle after the edge that takes the write. A tick-driven compare action is visible after the edge whose tick makes the counter reach RA or wrap at RC. A behavioural reference model of the tick schedule, the count and the output is stepped at every rising edge and compared with waveOut at every falling edge. Directed checks measure periods and high times in clk cycles, using the prescaled tick count times the divisor. They skip the first, partial period after each reprogramming.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic step;
  } strobe_t;

  function automatic logic applyAct(input act_e act, input logic cur);
    case (act)
      ACT_SET: applyAct = 1'b1;
      ACT_CLR: applyAct = 1'b0;
      ACT_TGL: applyAct = ~cur;
      default: applyAct = cur;
    endcase
  endfunction
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SEL = 4,
  localparam int SEL_W  = $clog2(NUM_SEL),
  localparam int PRE_W  = 2 * NUM_SEL - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [SEL_W-1:0] clkSel,
  output strobe_t          stb,
  output logic [CNT_W-1:0] raVal,
  output logic [CNT_W-1:0] rcVal,
  output act_e             raAct,
  output act_e             rcAct,
  output act_e             trgAct
);
  logic [PRE_W-1:0]   preCnt;
  logic [NUM_SEL-1:0] tickVec;
  logic               tick;
  logic               clkOn, running;
  logic               cmdWr, cmdEn, cmdDis, cmdTrg;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // one tick every 2^(2k+1) cycles for select k
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_tick
    assign tickVec[k] = &preCnt[2*k:0];
  end
  assign tick = tickVec[clkSel];

  assign cmdWr  = wrEn && (wrAddr == 2'd0);
  assign cmdEn  = cmdWr && wrData[0];
  assign cmdDis = cmdWr && wrData[1];
  assign cmdTrg = cmdWr && wrData[2];

  always_comb begin
    stb.restart = cmdTrg && !cmdDis && (clkOn || cmdEn);
    stb.step    = running && tick && !cmdDis && !stb.restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkOn   <= 1'b0;
      running <= 1'b0;
      raVal   <= '0;
      rcVal   <= '0;
      raAct   <= ACT_NONE;
      rcAct   <= ACT_NONE;
      trgAct  <= ACT_NONE;
    end else begin
      if (cmdDis) begin
        clkOn   <= 1'b0;
        running <= 1'b0;
      end else begin
        if (cmdEn)       clkOn   <= 1'b1;
        if (stb.restart) running <= 1'b1;
      end
      if (wrEn && wrAddr == 2'd1) begin
        raAct  <= act_e'(wrData[1:0]);
        rcAct  <= act_e'(wrData[3:2]);
        trgAct <= act_e'(wrData[5:4]);
      end
      if (wrEn && wrAddr == 2'd2) raVal <= wrData;
      if (wrEn && wrAddr == 2'd3) rcVal <= wrData;
    end
  end

  // R10
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDis |=> (!clkOn && !running));

  // R2
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cmdTrg) |=> !running);

  // R10
  trig_needs_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkOn && !cmdEn) |-> !stb.restart);
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] raVal,
  input  logic [CNT_W-1:0] rcVal,
  input  act_e             raAct,
  input  act_e             rcAct,
  input  act_e             trgAct,
  output logic             waveOut
);
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             atTop, rcHit, raHit;

  always_comb begin
    atTop   = (rcVal != '0) && (cnt >= rcVal - 1'b1);
    nextCnt = atTop ? '0 : cnt + 1'b1;
    rcHit   = stb.step && atTop;
    raHit   = stb.step && (rcVal != '0) && (nextCnt == raVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      waveOut <= 1'b0;
    end else begin
      if (stb.restart)                        cnt <= '0;
      else if (stb.step && rcVal != '0)       cnt <= nextCnt;
      if (stb.restart)  waveOut <= applyAct(trgAct, waveOut);
      else if (rcHit)   waveOut <= applyAct(rcAct, waveOut);
      else if (raHit)   waveOut <= applyAct(raAct, waveOut);
    end
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (cnt == '0));

  // R9
  rc_zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.restart && rcVal == '0 && cnt == '0) |=> (cnt == '0));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.restart && rcVal != '0 && cnt >= rcVal - 1'b1) |=> (cnt == '0));

  // R10
  frozen_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.restart && !stb.step) |=> $stable(waveOut));
endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
  import wt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SEL = 4,
  localparam int SEL_W  = $clog2(NUM_SEL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [SEL_W-1:0] clkSel,
  output logic             waveOut
);
  strobe_t          stb;
  logic [CNT_W-1:0] raVal, rcVal;
  act_e             raAct, rcAct, trgAct;

  wt_ctrl #(.CNT_W(CNT_W), .NUM_SEL(NUM_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkSel(clkSel), .stb(stb), .raVal(raVal), .rcVal(rcVal),
    .raAct(raAct), .rcAct(rcAct), .trgAct(trgAct)
  );

  wt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .raVal(raVal), .rcVal(rcVal),
    .raAct(raAct), .rcAct(rcAct), .trgAct(trgAct), .waveOut(waveOut)
  );
endmodule

// File: tb/tb_cmp_wave_timer.sv
`timescale 1ns/1ps
module tb_cmp_wave_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  clkSel = '0;
  logic        waveOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  cmp_wave_timer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                      .wrData(wrData), .clkSel(clkSel), .waveOut(waveOut));

  always #2.5 clk = ~clk;

  // behavioural reference model
  int  mPre = 0, mCnt = 0, mRa = 0, mRc = 0;
  int  mActA = 0, mActC = 0, mActT = 0;
  bit  mOn = 0, mRun = 0, mOut = 0;

  function automatic bit doAct(int a, bit cur);
    if (a == 1) return 1'b1;
    if (a == 2) return 1'b0;
    if (a == 3) return !cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mRa = 0; mRc = 0; mActA = 0; mActC = 0; mActT = 0;
      mOn = 0; mRun = 0; mOut = 0;
    end else begin
      int  div;
      bit  tk, isCmd, en, dis, trg, restart;
      div = 2 ** (2 * clkSel + 1);
      tk  = (mPre % div) == div - 1;
      mPre++;
      isCmd = wrEn && wrAddr == 0;
      en = isCmd && wrData[0]; dis = isCmd && wrData[1]; trg = isCmd && wrData[2];
      restart = trg && !dis && (mOn || en);
      if (restart) begin
        mCnt = 0; mOut = doAct(mActT, mOut);
      end else if (mRun && tk && !dis && mRc != 0) begin
        if (mCnt >= mRc - 1) begin
          mCnt = 0; mOut = doAct(mActC, mOut);
        end else begin
          mCnt++;
          if (mCnt == mRa) mOut = doAct(mActA, mOut);
        end
      end
      if (dis) begin mOn = 0; mRun = 0; end
      else begin
        if (en) mOn = 1;
        if (restart) mRun = 1;
      end
      if (wrEn && wrAddr == 1) begin
        mActA = wrData[1:0]; mActC = wrData[3:2]; mActT = wrData[5:4];
      end
      if (wrEn && wrAddr == 2) mRa = wrData;
      if (wrEn && wrAddr == 3) mRc = wrData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (waveOut !== mOut) begin
        errors++;
        $display("FAIL %s model compare: actual %0b expected %0b at %0t", curReq, waveOut, mOut, $time);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns period (rise to rise) and high time of second full period
  task automatic measure(output int per, output int hi);
    int c;
    per = 0; hi = 0;
    for (int rep = 0; rep < 2; rep++) begin
      c = 0;
      while (waveOut !== 1'b0 && c < 2000) begin @(negedge clk); c++; end
      c = 0;
      while (waveOut !== 1'b1 && c < 2000) begin @(negedge clk); c++; end
      hi = 0;
      while (waveOut === 1'b1 && hi < 2000) begin @(negedge clk); hi++; end
      per = hi;
      c = 0;
      while (waveOut === 1'b0 && c < 2000) begin @(negedge clk); c++; end
      per += c;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, hi;
    bit held;
    idle(4);
    check("R1 reset out", waveOut, 0);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    check("R1 idle after reset", waveOut, 0);

    // R6 mode: RA set, RC clear, trigger set
    curReq = "R2";
    wr(1, 16'h0019); wr(2, 16'd1); wr(3, 16'd2);
    wr(0, 16'h0001);
    held = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (waveOut !== 1'b0) held = 0; end
    check("R2 enable alone no activity", held, 1);

    curReq = "R3";
    wr(1, 16'h0029);              // trigger action clear
    wr(0, 16'h0002);
    @(negedge clk); wrEn = 1'b1; wrAddr = 0; wrData = 16'h0005;
    @(negedge clk); wrEn = 1'b0;
    check("R3 trigger clear applied at write edge", waveOut, 0);
    wr(1, 16'h0019);
    @(negedge clk); wrEn = 1'b1; wrAddr = 0; wrData = 16'h0004;
    @(negedge clk); wrEn = 1'b0;
    check("R3 trigger set applied at write edge", waveOut, 1);

    curReq = "R4";
    measure(per, hi);
    check("R4 period RC=2", per, 4);
    check("R4 high RC=2 RA=1", hi, 2);

    curReq = "R11";
    wr(3, 16'd4);
    measure(per, hi);
    check("R11 period after RC change", per, 8);
    check("R11 high after RC change", hi, 6);
    wr(2, 16'd3);
    measure(per, hi);
    check("R11 high after RA change", hi, 2);

    curReq = "R5";
    wr(1, 16'h002C); wr(2, 16'd0); wr(0, 16'h0004);
    measure(per, hi);
    check("R5 toggle period RC=4", per, 16);

    curReq = "R7";
    clkSel = 2'd1;
    measure(per, hi);
    check("R7 divide 8 period", per, 64);
    clkSel = 2'd2;
    measure(per, hi);
    check("R7 divide 32 period", per, 256);
    clkSel = 2'd0;
    wr(3, 16'd3);
    measure(per, hi);
    check("R7 divide 2 period RC=3", per, 12);

    curReq = "R8";
    wr(1, 16'h0019); wr(2, 16'd0); wr(0, 16'h0004);   // RA=0 set vs RC clear at wrap
    idle(20);
    held = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (waveOut !== 1'b0) held = 0; end
    check("R8 RC wins over RA at wrap", held, 1);
    wr(1, 16'h001F);                                   // all toggle, trigger set
    for (int i = 0; i < 6; i++) begin
      wr(0, 16'h0004);
      check("R8 trigger action wins", waveOut, 1);
    end

    curReq = "R9";
    wr(3, 16'd0); wr(1, 16'h001F); wr(0, 16'h0004);
    held = 1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (waveOut !== 1'b1) held = 0; end
    check("R9 RC zero holds output", held, 1);

    curReq = "R10";
    wr(3, 16'd5); wr(1, 16'h003C); wr(0, 16'h0004);
    idle(13);
    wr(0, 16'h0002);
    hi = waveOut;
    held = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (waveOut !== hi[0]) held = 0; end
    check("R10 disable freezes output", held, 1);
    wr(0, 16'h0003);
    wr(0, 16'h0004);
    held = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (waveOut !== hi[0]) held = 0; end
    check("R10 disable wins, trigger ignored", held, 1);
    wr(0, 16'h0005);
    check("R10 restart after re-enable toggles", waveOut, !hi[0]);
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule